// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a virtual byte address from a load/store unit into a physical byte address. Each request carries an address, an access size and a read/write flag. One cycle after the request is accepted, the block returns either a physical address or a single exception code, together with the virtual address that was presented. The checks run in a fixed order: alignment first, then mapping, then write protection, then frame range. A successful translation marks the entry as referenced, and a successful write also marks it as modified.

The lookup structure is chosen at build time by the `USE_TLB` parameter, so exactly one structure exists in any build. With `USE_TLB=0` the block uses a linear page table indexed directly by page number. With `USE_TLB=1` it uses a small fully associative table that software refills after a miss. Software loads entries through a one-index-per-cycle write port and reads them back, including the referenced and modified bits, through a combinational read port. The page size is a power of two, so the address splits into page number and offset by a bit slice.

Top module: `vat_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every entry reads back with valid, read-only, referenced and modified all 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. The response appears with `rsp_valid`=1 on the next cycle. While `rsp_ready` is 0 the response holds steady and `req_ready` is 0.
- R3: Size codes are 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. A 2-byte access with address bit 0 set, or a 4-byte access with either of address bits 1:0 set, returns exception code 1 (address error) whatever the mapping is. The exception codes are 0 none, 1 address error, 2 page fault, 3 read-only, 4 bus error.
- R4: When there is no exception, `rsp_paddr` equals frame × page size + (address mod page size). On any exception `rsp_paddr` is 0. `rsp_vaddr` always echoes the accepted address.
- R5: In page-table mode, entry n maps page n. A page number at or above `PT_ENTRIES` returns code 1. An entry whose valid bit is clear returns code 2.
- R6: In associative mode, a miss returns code 2. When several valid entries hold the requested page, the one with the lowest index is used.
- R7: A write that hits a read-only entry returns code 3. This check applies only after the lookup has succeeded.
- R8: A frame number at or above `PHYS_PAGES` returns code 4. This check comes after the read-only check.
- R9: A translation with no exception sets the entry's referenced bit, and also its modified bit when the access is a write. A translation that faults changes neither bit.
- R10: A write to an entry takes effect from the next cycle. A lookup in the same cycle uses the old contents, and the written values take precedence over that lookup's bit updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | ADDR_W | Virtual byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for a store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_exc | output | 3 | Exception code |
| rsp_paddr | output | PA_W | Physical byte address |
| rsp_vaddr | output | ADDR_W | Echo of the translated address |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry index to write |
| ent_vpage | input | VPN_W | Virtual page (used for matching in associative mode) |
| ent_frame | input | FRM_W | Physical frame number |
| ent_valid | input | 1 | Valid bit to load |
| ent_rdonly | input | 1 | Read-only bit to load |
| ent_touched | input | 1 | Referenced bit to load |
| ent_dirty | input | 1 | Modified bit to load |
| rd_idx | input | IDX_W | Entry index to read back |
| rd_vpage | output | VPN_W | Stored virtual page |
| rd_frame | output | FRM_W | Stored frame |
| rd_valid | output | 1 | Stored valid bit |
| rd_rdonly | output | 1 | Stored read-only bit |
| rd_touched | output | 1 | Stored referenced bit |
| rd_dirty | output | 1 | Stored modified bit |

## Verification
The hardest case to reach from the ports is an entry write that lands in the same cycle as a lookup of that entry. Here the old mapping must still translate, and the written flags must override the referenced-bit update. The bench raises the entry write strobe and the request in the same cycle, then issues a second lookup to show that the new contents apply. The check order is exercised by a sweep. It covers every page number up to past the table end, all sizes, both directions and three offset alignments, against tables that contain invalid, read-only and out-of-range frames, including entries that are both read-only and out of range. The associative table also holds a duplicate page so that lowest-index selection is observable.

// File: rtl/vat_pkg.sv
package vat_pkg;

    typedef enum logic [2:0] {
        EXC_NONE   = 3'd0,
        EXC_ADDR   = 3'd1,
        EXC_PAGE   = 3'd2,
        EXC_RDONLY = 3'd3,
        EXC_BUS    = 3'd4
    } exc_e;

    typedef struct packed {
        logic valid;
        logic rdonly;
        logic touched;
        logic dirty;
    } ent_flags_t;

    // size code: 0 byte, 1 half, 2/3 word
    function automatic logic misaligned(logic [1:0] size, logic [1:0] lo);
        case (size)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            default: return |lo;
        endcase
    endfunction

    // fixed priority: alignment, mapping, protection, frame range
    function automatic exc_e classify(logic misal, logic oob, logic hit,
                                      logic rdonly, logic write, logic frame_bad);
        if (misal)                 return EXC_ADDR;
        else if (oob)              return EXC_ADDR;
        else if (!hit)             return EXC_PAGE;
        else if (rdonly && write)  return EXC_RDONLY;
        else if (frame_bad)        return EXC_BUS;
        else                       return EXC_NONE;
    endfunction

endpackage

// File: rtl/vat_align_check.sv
module vat_align_check
    import vat_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misal
);
    always_comb misal = misaligned(size, addr_lo);
endmodule

// File: rtl/vat_pt_store.sv
module vat_pt_store
    import vat_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 25,
    parameter int FRM_W   = 6,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [FRM_W-1:0] wr_frame,
    input  ent_flags_t       wr_flags,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_oob,
    output logic [IDX_W-1:0] lk_idx,
    output logic [FRM_W-1:0] lk_frame,
    output logic             lk_rdonly,
    input  logic             mk_en,
    input  logic [IDX_W-1:0] mk_idx,
    input  logic             mk_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_vpn,
    output logic [FRM_W-1:0] rd_frame,
    output ent_flags_t       rd_flags
);
    localparam logic [VPN_W-1:0] LIMIT = VPN_W'(ENTRIES);

    logic [VPN_W-1:0] vpn_q   [ENTRIES];
    logic [FRM_W-1:0] frame_q [ENTRIES];
    ent_flags_t       flags_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                vpn_q[g]   <= '0;
                frame_q[g] <= '0;
                flags_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vpn_q[g]   <= wr_vpn;
                frame_q[g] <= wr_frame;
                flags_q[g] <= wr_flags;
            end else if (mk_en && mk_idx == IDX_W'(g)) begin
                flags_q[g].touched <= 1'b1;
                if (mk_dirty) flags_q[g].dirty <= 1'b1;
            end
        end
    end

    always_comb begin
        lk_oob    = (lk_vpn >= LIMIT);
        lk_idx    = lk_vpn[IDX_W-1:0];
        lk_hit    = !lk_oob && flags_q[lk_idx].valid;
        lk_frame  = frame_q[lk_idx];
        lk_rdonly = flags_q[lk_idx].rdonly;
        rd_vpn    = vpn_q[rd_idx];
        rd_frame  = frame_q[rd_idx];
        rd_flags  = flags_q[rd_idx];
    end
endmodule

// File: rtl/vat_tlb_store.sv
module vat_tlb_store
    import vat_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 25,
    parameter int FRM_W   = 6,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [FRM_W-1:0] wr_frame,
    input  ent_flags_t       wr_flags,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_oob,
    output logic [IDX_W-1:0] lk_idx,
    output logic [FRM_W-1:0] lk_frame,
    output logic             lk_rdonly,
    input  logic             mk_en,
    input  logic [IDX_W-1:0] mk_idx,
    input  logic             mk_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_vpn,
    output logic [FRM_W-1:0] rd_frame,
    output ent_flags_t       rd_flags
);
    logic [VPN_W-1:0] vpn_q   [ENTRIES];
    logic [FRM_W-1:0] frame_q [ENTRIES];
    ent_flags_t       flags_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                vpn_q[g]   <= '0;
                frame_q[g] <= '0;
                flags_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vpn_q[g]   <= wr_vpn;
                frame_q[g] <= wr_frame;
                flags_q[g] <= wr_flags;
            end else if (mk_en && mk_idx == IDX_W'(g)) begin
                flags_q[g].touched <= 1'b1;
                if (mk_dirty) flags_q[g].dirty <= 1'b1;
            end
        end
    end

    // scan downwards so the lowest matching index is the last one written
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (flags_q[i].valid && vpn_q[i] == lk_vpn) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
        lk_oob    = 1'b0;
        lk_frame  = frame_q[lk_idx];
        lk_rdonly = flags_q[lk_idx].rdonly;
        rd_vpn    = vpn_q[rd_idx];
        rd_frame  = frame_q[rd_idx];
        rd_flags  = flags_q[rd_idx];
    end
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_BYTES  = 128,
    parameter int USE_TLB     = 0,
    parameter int TLB_ENTRIES = 4,
    parameter int PT_ENTRIES  = 32,
    parameter int PHYS_PAGES  = 32,
    localparam int OFF_W   = $clog2(PAGE_BYTES),
    localparam int VPN_W   = ADDR_W - OFF_W,
    localparam int FRM_W   = $clog2(PHYS_PAGES) + 1,
    localparam int PA_W    = OFF_W + FRM_W - 1,
    localparam int NUM_ENT = (USE_TLB != 0) ? TLB_ENTRIES : PT_ENTRIES,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_exc,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ADDR_W-1:0] rsp_vaddr,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [VPN_W-1:0]  ent_vpage,
    input  logic [FRM_W-1:0]  ent_frame,
    input  logic              ent_valid,
    input  logic              ent_rdonly,
    input  logic              ent_touched,
    input  logic              ent_dirty,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VPN_W-1:0]  rd_vpage,
    output logic [FRM_W-1:0]  rd_frame,
    output logic              rd_valid,
    output logic              rd_rdonly,
    output logic              rd_touched,
    output logic              rd_dirty
);
    localparam logic [FRM_W-1:0] FRAME_LIMIT = FRM_W'(PHYS_PAGES);

    logic             accept;
    logic             misal;
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] offset;
    logic             lk_hit, lk_oob, lk_rdonly;
    logic [IDX_W-1:0] lk_idx;
    logic [FRM_W-1:0] lk_frame;
    exc_e             exc;
    logic             mk_en;
    ent_flags_t       wr_flags, rd_flags;
    logic [PA_W-1:0]  paddr;

    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign vpn       = req_vaddr[ADDR_W-1:OFF_W];
    assign offset    = req_vaddr[OFF_W-1:0];
    assign wr_flags  = '{valid: ent_valid, rdonly: ent_rdonly,
                         touched: ent_touched, dirty: ent_dirty};

    vat_align_check i_align (
        .size    (req_size),
        .addr_lo (req_vaddr[1:0]),
        .misal   (misal)
    );

    if (USE_TLB != 0) begin : g_tlb
        vat_tlb_store #(
            .ENTRIES(NUM_ENT), .VPN_W(VPN_W), .FRM_W(FRM_W), .IDX_W(IDX_W)
        ) i_store (
            .clk(clk), .rst(rst),
            .wr_en(ent_we), .wr_idx(ent_idx), .wr_vpn(ent_vpage),
            .wr_frame(ent_frame), .wr_flags(wr_flags),
            .lk_vpn(vpn), .lk_hit(lk_hit), .lk_oob(lk_oob), .lk_idx(lk_idx),
            .lk_frame(lk_frame), .lk_rdonly(lk_rdonly),
            .mk_en(mk_en), .mk_idx(lk_idx), .mk_dirty(req_write),
            .rd_idx(rd_idx), .rd_vpn(rd_vpage), .rd_frame(rd_frame),
            .rd_flags(rd_flags)
        );
    end else begin : g_pt
        vat_pt_store #(
            .ENTRIES(NUM_ENT), .VPN_W(VPN_W), .FRM_W(FRM_W), .IDX_W(IDX_W)
        ) i_store (
            .clk(clk), .rst(rst),
            .wr_en(ent_we), .wr_idx(ent_idx), .wr_vpn(ent_vpage),
            .wr_frame(ent_frame), .wr_flags(wr_flags),
            .lk_vpn(vpn), .lk_hit(lk_hit), .lk_oob(lk_oob), .lk_idx(lk_idx),
            .lk_frame(lk_frame), .lk_rdonly(lk_rdonly),
            .mk_en(mk_en), .mk_idx(lk_idx), .mk_dirty(req_write),
            .rd_idx(rd_idx), .rd_vpn(rd_vpage), .rd_frame(rd_frame),
            .rd_flags(rd_flags)
        );
    end

    always_comb begin
        exc   = classify(misal, lk_oob, lk_hit, lk_rdonly, req_write,
                         lk_frame >= FRAME_LIMIT);
        mk_en = accept && (exc == EXC_NONE);
        paddr = {lk_frame[FRM_W-2:0], offset};
    end

    assign rd_valid   = rd_flags.valid;
    assign rd_rdonly  = rd_flags.rdonly;
    assign rd_touched = rd_flags.touched;
    assign rd_dirty   = rd_flags.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_exc   <= EXC_NONE;
            rsp_paddr <= '0;
            rsp_vaddr <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_exc   <= exc;
            rsp_paddr <= (exc == EXC_NONE) ? paddr : '0;
            rsp_vaddr <= req_vaddr;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/vat_unit_checker.sv
module vat_unit_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7,
    parameter int PA_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [2:0]        rsp_exc,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [ADDR_W-1:0] rsp_vaddr
);
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> rsp_valid);

    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_exc)
                                    && $stable(rsp_paddr) && $stable(rsp_vaddr));

    a_r3_word_align: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_size[1] && (req_vaddr[1:0] != 2'b00)
        |=> rsp_exc == 3'd1);

    a_r3_half_align: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_size == 2'd1 && req_vaddr[0]
        |=> rsp_exc == 3'd1);

    a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_exc <= 3'd4);

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_exc == 3'd0
        |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);

    a_r4_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_exc != 3'd0 |-> rsp_paddr == '0);
endmodule

bind vat_unit vat_unit_checker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PA_W(PA_W)
) i_vat_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr),
    .rsp_vaddr(rsp_vaddr)
);

// File: tb/test_vat_unit.sv
module test_vat_unit;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_size = '0;
    logic [8:0]  wr_vpage = '0;
    logic [5:0]  wr_frame = '0;
    logic        wr_valid = 1'b0, wr_rdonly = 1'b0, wr_touched = 1'b0, wr_dirty = 1'b0;

    logic        pt_we = 1'b0;
    logic [4:0]  pt_widx = '0, pt_ridx = '0;
    logic        pt_req_ready, pt_rsp_valid;
    logic [2:0]  pt_rsp_exc;
    logic [11:0] pt_rsp_paddr;
    logic [15:0] pt_rsp_vaddr;
    logic [8:0]  pt_rd_vpage;
    logic [5:0]  pt_rd_frame;
    logic        pt_rd_valid, pt_rd_rdonly, pt_rd_touched, pt_rd_dirty;

    logic        tl_we = 1'b0;
    logic [1:0]  tl_widx = '0, tl_ridx = '0;
    logic        tl_req_ready, tl_rsp_valid;
    logic [2:0]  tl_rsp_exc;
    logic [11:0] tl_rsp_paddr;
    logic [15:0] tl_rsp_vaddr;
    logic [8:0]  tl_rd_vpage;
    logic [5:0]  tl_rd_frame;
    logic        tl_rd_valid, tl_rd_rdonly, tl_rd_touched, tl_rd_dirty;

    vat_unit #(.ADDR_W(AW), .USE_TLB(0)) i_vat_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(pt_req_ready),
        .req_vaddr(req_vaddr), .req_size(req_size), .req_write(req_write),
        .rsp_valid(pt_rsp_valid), .rsp_ready(rsp_ready), .rsp_exc(pt_rsp_exc),
        .rsp_paddr(pt_rsp_paddr), .rsp_vaddr(pt_rsp_vaddr),
        .ent_we(pt_we), .ent_idx(pt_widx), .ent_vpage(wr_vpage), .ent_frame(wr_frame),
        .ent_valid(wr_valid), .ent_rdonly(wr_rdonly), .ent_touched(wr_touched),
        .ent_dirty(wr_dirty), .rd_idx(pt_ridx), .rd_vpage(pt_rd_vpage),
        .rd_frame(pt_rd_frame), .rd_valid(pt_rd_valid), .rd_rdonly(pt_rd_rdonly),
        .rd_touched(pt_rd_touched), .rd_dirty(pt_rd_dirty)
    );

    vat_unit #(.ADDR_W(AW), .USE_TLB(1)) i_vat_unit_tlb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(tl_req_ready),
        .req_vaddr(req_vaddr), .req_size(req_size), .req_write(req_write),
        .rsp_valid(tl_rsp_valid), .rsp_ready(rsp_ready), .rsp_exc(tl_rsp_exc),
        .rsp_paddr(tl_rsp_paddr), .rsp_vaddr(tl_rsp_vaddr),
        .ent_we(tl_we), .ent_idx(tl_widx), .ent_vpage(wr_vpage), .ent_frame(wr_frame),
        .ent_valid(wr_valid), .ent_rdonly(wr_rdonly), .ent_touched(wr_touched),
        .ent_dirty(wr_dirty), .rd_idx(tl_ridx), .rd_vpage(tl_rd_vpage),
        .rd_frame(tl_rd_frame), .rd_valid(tl_rd_valid), .rd_rdonly(tl_rd_rdonly),
        .rd_touched(tl_rd_touched), .rd_dirty(tl_rd_dirty)
    );

    int checks = 0;
    int fails  = 0;

    int pt_f [32];
    bit pt_v [32], pt_r [32], pt_u [32], pt_d [32];
    int tl_vp [4], tl_f [4];
    bit tl_v [4], tl_r [4], tl_u [4], tl_d [4];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit misal_of(int va, int sz);
        if (sz == 1) return va[0];
        if (sz >= 2) return (va % 4) != 0;
        return 1'b0;
    endfunction

    function automatic string tag_of(int e);
        case (e)
            0: return "R4 translate";
            1: return "R3 R5 address error";
            2: return "R5 R6 page fault";
            3: return "R7 read-only";
            default: return "R8 bus error";
        endcase
    endfunction

    function automatic void exp_pt(int va, int sz, bit wr, output int e, output int pa, output int idx);
        int vpn = va / 128;
        idx = vpn;
        if (misal_of(va, sz))            e = 1;
        else if (vpn >= 32)              e = 1;
        else if (!pt_v[vpn])             e = 2;
        else if (pt_r[vpn] && wr)        e = 3;
        else if (pt_f[vpn] >= 32)        e = 4;
        else                             e = 0;
        pa = (e == 0) ? pt_f[vpn] * 128 + va % 128 : 0;
    endfunction

    function automatic void exp_tl(int va, int sz, bit wr, output int e, output int pa, output int idx);
        int vpn = va / 128;
        idx = -1;
        for (int i = 0; i < 4; i++)
            if (idx < 0 && tl_v[i] && tl_vp[i] == vpn) idx = i;
        if (misal_of(va, sz))            e = 1;
        else if (idx < 0)                e = 2;
        else if (tl_r[idx] && wr)        e = 3;
        else if (tl_f[idx] >= 32)        e = 4;
        else                             e = 0;
        pa = (e == 0) ? tl_f[idx] * 128 + va % 128 : 0;
    endfunction

    task automatic set_wr(int vp, int fr, bit v, bit r, bit u, bit d);
        wr_vpage = vp[8:0]; wr_frame = fr[5:0];
        wr_valid = v; wr_rdonly = r; wr_touched = u; wr_dirty = d;
    endtask

    task automatic load_pt(int i, int fr, bit v, bit r);
        @(negedge clk);
        set_wr(0, fr, v, r, 1'b0, 1'b0);
        pt_we = 1'b1; pt_widx = i[4:0];
        @(negedge clk);
        pt_we = 1'b0;
        pt_f[i] = fr; pt_v[i] = v; pt_r[i] = r; pt_u[i] = 1'b0; pt_d[i] = 1'b0;
    endtask

    task automatic load_tl(int i, int vp, int fr, bit v, bit r);
        @(negedge clk);
        set_wr(vp, fr, v, r, 1'b0, 1'b0);
        tl_we = 1'b1; tl_widx = i[1:0];
        @(negedge clk);
        tl_we = 1'b0;
        tl_vp[i] = vp; tl_f[i] = fr; tl_v[i] = v; tl_r[i] = r; tl_u[i] = 1'b0; tl_d[i] = 1'b0;
    endtask

    // one request to both units; optional same-cycle entry write (data from set_wr)
    task automatic do_req(int va, int sz, bit wr, bit with_wr, int pwi, int twi);
        int pe, ppa, pi, te, tpa, ti;
        exp_pt(va, sz, wr, pe, ppa, pi);
        exp_tl(va, sz, wr, te, tpa, ti);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va[15:0]; req_size = sz[1:0]; req_write = wr;
        if (with_wr) begin
            pt_we = 1'b1; pt_widx = pwi[4:0];
            tl_we = 1'b1; tl_widx = twi[1:0];
        end
        @(negedge clk);
        req_valid = 1'b0; pt_we = 1'b0; tl_we = 1'b0;
        chk($sformatf("PT %s va=%0h sz=%0d wr=%0d", tag_of(pe), va, sz, wr),
            int'({pt_rsp_valid, pt_rsp_exc, pt_rsp_paddr}), int'({1'b1, pe[2:0], ppa[11:0]}));
        chk($sformatf("TLB %s va=%0h sz=%0d wr=%0d", tag_of(te), va, sz, wr),
            int'({tl_rsp_valid, tl_rsp_exc, tl_rsp_paddr}), int'({1'b1, te[2:0], tpa[11:0]}));
        chk("R4 vaddr echo", int'({pt_rsp_vaddr, tl_rsp_vaddr}), int'({va[15:0], va[15:0]}));
        if (pe == 0) begin pt_u[pi] = 1'b1; if (wr) pt_d[pi] = 1'b1; end
        if (te == 0) begin tl_u[ti] = 1'b1; if (wr) tl_d[ti] = 1'b1; end
        if (with_wr) begin
            pt_f[pwi] = wr_frame; pt_v[pwi] = wr_valid; pt_r[pwi] = wr_rdonly;
            pt_u[pwi] = wr_touched; pt_d[pwi] = wr_dirty;
            tl_vp[twi] = wr_vpage; tl_f[twi] = wr_frame; tl_v[twi] = wr_valid;
            tl_r[twi] = wr_rdonly; tl_u[twi] = wr_touched; tl_d[twi] = wr_dirty;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pt_ridx = 5'd0; tl_ridx = 2'd0;
        #1;
        // R1: idle after reset, entries cleared
        chk("R1 rsp_valid/req_ready", int'({pt_rsp_valid, pt_req_ready, tl_rsp_valid, tl_req_ready}), 32'b0101);
        chk("R1 entry flags", int'({pt_rd_valid, pt_rd_rdonly, pt_rd_touched, pt_rd_dirty,
                                    tl_rd_valid, tl_rd_rdonly, tl_rd_touched, tl_rd_dirty}), 0);

        for (int i = 0; i < 32; i++)
            load_pt(i, (i * 7 + 3) % 40, (i % 5) != 4, (i % 3) == 1);
        load_tl(0, 5, 3, 1'b1, 1'b0);
        load_tl(1, 9, 10, 1'b1, 1'b1);
        load_tl(2, 5, 7, 1'b1, 1'b0);
        load_tl(3, 12, 35, 1'b1, 1'b0);

        // R10: contents written through the port read back
        pt_ridx = 5'd7; tl_ridx = 2'd1;
        #1;
        chk("R10 PT readback", int'({pt_rd_frame, pt_rd_valid, pt_rd_rdonly}), int'({6'd12, 1'b1, 1'b1}));
        chk("R10 TLB readback", int'({tl_rd_vpage, tl_rd_frame, tl_rd_valid, tl_rd_rdonly}),
            int'({9'd9, 6'd10, 1'b1, 1'b1}));

        // sweep: R3..R8 and R9 model tracking
        for (int vpn = 0; vpn < 40; vpn++)
            for (int k = 0; k < 3; k++)
                for (int sz = 0; sz < 3; sz++)
                    for (int wr = 0; wr < 2; wr++)
                        do_req(vpn * 128 + ((vpn * 4 + k) % 128), sz, wr[0], 1'b0, 0, 0);

        // R2: stalled response holds, then drains
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_vaddr = 16'(3 * 128 + 8); req_size = 2'd2; req_write = 1'b0;
        @(negedge clk);
        pt_u[3] = 1'b1;
        chk("R2 stall valid/ready", int'({pt_rsp_valid, pt_req_ready, tl_rsp_valid, tl_req_ready}), 32'b1010);
        req_vaddr = 16'(6 * 128);
        repeat (2) @(negedge clk);
        chk("R2 response held", int'({pt_rsp_vaddr, pt_rsp_exc}), int'({16'(3 * 128 + 8), 3'd0}));
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R2 drained", int'({pt_rsp_valid, tl_rsp_valid, pt_req_ready}), 32'b001);

        // R10: same-cycle write and lookup; old contents translate
        set_wr(0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_req(2 * 128 + 4, 2, 1'b0, 1'b1, 2, 0);
        // next lookup sees the new contents; TLB falls to the shadowed entry (R6)
        do_req(2 * 128 + 4, 2, 1'b0, 1'b0, 0, 0);
        do_req(5 * 128 + 20, 2, 1'b1, 1'b0, 0, 0);

        // R9: referenced/modified bits match the model
        for (int i = 0; i < 32; i++) begin
            pt_ridx = i[4:0];
            #1;
            chk($sformatf("R9 PT entry %0d flags", i),
                int'({pt_rd_valid, pt_rd_rdonly, pt_rd_touched, pt_rd_dirty}),
                int'({pt_v[i], pt_r[i], pt_u[i], pt_d[i]}));
        end
        for (int i = 0; i < 4; i++) begin
            tl_ridx = i[1:0];
            #1;
            chk($sformatf("R9 TLB entry %0d flags", i),
                int'({tl_rd_valid, tl_rd_rdonly, tl_rd_touched, tl_rd_dirty}),
                int'({tl_v[i], tl_r[i], tl_u[i], tl_d[i]}));
        end

        summary();
        $finish;
    end
endmodule